// File: doc/BRIEF.md
# GPIO Port Register File with Clear/Set/Toggle Aliases

This block holds the configuration and state registers of one 16-bit general-purpose I/O port. It has eight registers: the port data value, two interrupt mask words (A and B), direction, polarity, edge select, both-edge select and input enable. A simple synchronous bus reaches them at 17 word-aligned addresses. The data register and both mask registers each have three extra addresses. Writing to one of these clears, sets or toggles the bits of the target register where the written word has a one. Reading one of these extra addresses returns the register it acts on.

Every register value goes straight out to the pin and interrupt logic next to the block. That logic can write single bits of the data register back through a per-bit enable and value pair. In any cycle where the bus writes the data register, through its base address or any of its aliases, the bus write wins and the pin update is dropped. The bus signals an error for two kinds of access. One is an access whose size is not 16 bits. The other is an access to an address outside the register map. An access that raises the error changes no register.

Top module: `gpio_regfile`

## Requirements
- R1: While `rst_n` is low, and right after it is released, all eight register outputs, `bus_rdata` and `bus_err` are zero.
- R2: A legal write to a base address replaces the whole register. The base addresses are 0x00 data, 0x10 mask A, 0x20 mask B, 0x30 direction, 0x34 polarity, 0x38 edge select, 0x3C both-edge and 0x40 input enable. The new value appears on the register output after the next rising clock edge.
- R3: A legal write to a clear alias clears each bit of the target register where `bus_wdata` is 1. The clear aliases are 0x04 for data, 0x14 for mask A and 0x24 for mask B.
- R4: A legal write to a set alias ORs `bus_wdata` into the target register. The set aliases are 0x08 for data, 0x18 for mask A and 0x28 for mask B.
- R5: A legal write to a toggle alias XORs `bus_wdata` into the target register. The toggle aliases are 0x0C for data, 0x1C for mask A and 0x2C for mask B.
- R6: A legal read puts the addressed register value, as it stood before that edge, on `bus_rdata` one cycle later. A read of any alias returns its base register. In any cycle without a legal read, `bus_rdata` is zero.
- R7: A read or write with `bus_size` other than 2'b01 (the 16-bit size code) raises `bus_err` in the following cycle and changes no register.
- R8: A read or write to an offset that is not a multiple of 4, or that is above 0x40, raises `bus_err` in the following cycle and changes no register. `bus_err` is low after any cycle with no illegal access.
- R9: In a cycle without a bus write to the data register or its aliases, each data bit whose `pin_upd_en` bit is 1 takes the matching `pin_upd_val` bit at the next edge. The other data bits keep their value.
- R10: When a bus write to the data register or any of its aliases happens in the same cycle as a pin update, the data register takes only the result of the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte offset of the access |
| bus_size | input | 2 | Access size code; 2'b01 is 16 bits, the only legal size |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| bus_err | output | 1 | Error pulse, one cycle after an illegal access |
| pin_upd_en | input | 16 | Per-bit enable for pin updates to the data register |
| pin_upd_val | input | 16 | Per-bit value for pin updates |
| data_q | output | 16 | Data register |
| maska_q | output | 16 | Interrupt mask A |
| maskb_q | output | 16 | Interrupt mask B |
| dir_q | output | 16 | Direction register |
| polar_q | output | 16 | Polarity register |
| edge_q | output | 16 | Edge-select register |
| both_q | output | 16 | Both-edge register |
| inen_q | output | 16 | Input-enable register |

## Verification
Each base register gets its own distinct pattern. This exposes a decode that sends a write to the wrong register. The clear, set and toggle aliases are each used on data, mask A and mask B with partly overlapping patterns, so replace, OR, AND-NOT and XOR give different results. Wrong-size accesses, misaligned offsets and offsets above 0x40 are driven with write data that would change state, so a missed check shows up as a register change. Pin updates are tried alone, next to a mask write and on top of data writes. This shows whether the pin path gives way only to the data family of addresses.

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int ADDR_W = 7,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic [DW-1:0]     pin_upd_en,
  input  logic [DW-1:0]     pin_upd_val,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     maska_q,
  output logic [DW-1:0]     maskb_q,
  output logic [DW-1:0]     dir_q,
  output logic [DW-1:0]     polar_q,
  output logic [DW-1:0]     edge_q,
  output logic [DW-1:0]     both_q,
  output logic [DW-1:0]     inen_q
);
  localparam int NREG = 17;
  localparam int LAST_OFF = (NREG - 1) * 4;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  logic [IDX_W-1:0] idx;
  logic legal, wr_ok, rd_ok, fam_wr;
  logic [1:0] grp, kind;
  logic [DW-1:0] rd_mux, data_n, maska_n, maskb_n;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign legal = (bus_size == SIZE_HALF) && (bus_addr[1:0] == 2'b00) &&
                 (bus_addr <= ADDR_W'(LAST_OFF));
  assign wr_ok = bus_wr & legal;
  assign rd_ok = bus_rd & legal;
  assign grp   = idx[3:2];
  assign kind  = idx[1:0];
  assign fam_wr = wr_ok && (idx < IDX_W'(12));

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] cur,
                                          input logic [DW-1:0] wd,
                                          input logic [1:0] k);
    case (k)
      2'd0:    apply = wd;
      2'd1:    apply = cur & ~wd;
      2'd2:    apply = cur | wd;
      default: apply = cur ^ wd;
    endcase
  endfunction

  assign data_n  = (fam_wr && grp == 2'd0) ? apply(data_q, bus_wdata, kind)
                                           : (data_q & ~pin_upd_en) | (pin_upd_val & pin_upd_en);
  assign maska_n = (fam_wr && grp == 2'd1) ? apply(maska_q, bus_wdata, kind) : maska_q;
  assign maskb_n = (fam_wr && grp == 2'd2) ? apply(maskb_q, bus_wdata, kind) : maskb_q;

  always_comb begin
    rd_mux = '0;
    if (idx < IDX_W'(12)) begin
      case (grp)
        2'd0:    rd_mux = data_q;
        2'd1:    rd_mux = maska_q;
        default: rd_mux = maskb_q;
      endcase
    end else begin
      case (int'(idx))
        12:      rd_mux = dir_q;
        13:      rd_mux = polar_q;
        14:      rd_mux = edge_q;
        15:      rd_mux = both_q;
        16:      rd_mux = inen_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; maska_q <= '0; maskb_q <= '0;
      dir_q <= '0; polar_q <= '0; edge_q <= '0; both_q <= '0; inen_q <= '0;
      bus_rdata <= '0;
      bus_err <= 1'b0;
    end else begin
      data_q  <= data_n;
      maska_q <= maska_n;
      maskb_q <= maskb_n;
      if (wr_ok && idx == IDX_W'(12)) dir_q   <= bus_wdata;
      if (wr_ok && idx == IDX_W'(13)) polar_q <= bus_wdata;
      if (wr_ok && idx == IDX_W'(14)) edge_q  <= bus_wdata;
      if (wr_ok && idx == IDX_W'(15)) both_q  <= bus_wdata;
      if (wr_ok && idx == IDX_W'(16)) inen_q  <= bus_wdata;
      bus_rdata <= rd_ok ? rd_mux : '0;
      bus_err   <= (bus_wr | bus_rd) & ~legal;
    end
  end
endmodule

module gpio_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  bus_addr,
  input logic [1:0]  bus_size,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        bus_err,
  input logic [15:0] pin_upd_en,
  input logic [15:0] pin_upd_val,
  input logic [15:0] data_q,
  input logic [15:0] maska_q,
  input logic [15:0] maskb_q,
  input logic [15:0] dir_q,
  input logic [15:0] polar_q,
  input logic [15:0] edge_q,
  input logic [15:0] both_q,
  input logic [15:0] inen_q
);
  logic [127:0] all_regs;
  assign all_regs = {data_q, maska_q, maskb_q, dir_q, polar_q, edge_q, both_q, inen_q};

  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_size != 2'b01) |=> bus_err);  // R7
  AST_BAD_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size != 2'b01 && pin_upd_en == 16'h0) |=> $stable(all_regs));  // R7
  AST_BAD_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr > 7'h40 || bus_addr[1:0] != 2'b00) && pin_upd_en == 16'h0)
      |=> ($stable(all_regs) && bus_err));  // R8
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> !bus_err);  // R8
  AST_MASKB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'b01 && bus_addr == 7'h24)
      |=> maskb_q == ($past(maskb_q) & ~$past(bus_wdata)));  // R3
  AST_MASKA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'b01 && bus_addr == 7'h18)
      |=> maska_q == ($past(maska_q) | $past(bus_wdata)));  // R4
  AST_DATA_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'b01 && bus_addr == 7'h0C)
      |=> data_q == ($past(data_q) ^ $past(bus_wdata)));  // R10
  AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 2'b01 && bus_addr == 7'h14)
      |=> bus_rdata == $past(maska_q));  // R6
  AST_PIN_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && pin_upd_en != 16'h0)
      |=> data_q == (($past(data_q) & ~$past(pin_upd_en)) |
                     ($past(pin_upd_val) & $past(pin_upd_en))));  // R9
endmodule

bind gpio_regfile gpio_regfile_chk u_chk (.*);

// File: tb/gpio_regfile_test.sv
`timescale 1ns/1ps
module gpio_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, pin_upd_en = '0, pin_upd_val = '0;
  logic [15:0] bus_rdata, data_q, maska_q, maskb_q, dir_q, polar_q, edge_q, both_q, inen_q;
  logic bus_err;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  logic done = 1'b0;

  always #5 clk = ~clk;

  gpio_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_upd_en(pin_upd_en), .pin_upd_val(pin_upd_val),
    .data_q(data_q), .maska_q(maska_q), .maskb_q(maskb_q), .dir_q(dir_q),
    .polar_q(polar_q), .edge_q(edge_q), .both_q(both_q), .inen_q(inen_q)
  );

  logic [15:0] m [8];
  logic [15:0] m_rd = '0;
  logic m_err = 1'b0;
  initial for (int i = 0; i < 8; i++) m[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      m_rd = '0;
      m_err = 1'b0;
    end else begin
      int off, r, slot, how;
      logic ok, data_written;
      logic [15:0] rv;
      off = int'(bus_addr);
      ok = (bus_size == 2'b01) && (off % 4 == 0) && (off <= 64);
      r = off / 4;
      slot = (r < 12) ? r / 4 : r - 9;
      how = (r < 12) ? r % 4 : 0;
      rv = m_rd;
      m_err = (bus_wr || bus_rd) && !ok;
      m_rd = (bus_rd && ok) ? m[slot] : 16'h0;
      data_written = 1'b0;
      if (bus_wr && ok) begin
        if (how == 0) m[slot] = bus_wdata;
        else if (how == 1) m[slot] = m[slot] & ~bus_wdata;
        else if (how == 2) m[slot] = m[slot] | bus_wdata;
        else m[slot] = m[slot] ^ bus_wdata;
        data_written = (slot == 0);
      end
      if (!data_written) m[0] = (m[0] & ~pin_upd_en) | (pin_upd_val & pin_upd_en);
      if (rv === 16'hxxxx) m_rd = m_rd;
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!done) begin
      chk("data", data_q, m[0]);
      chk("maska", maska_q, m[1]);
      chk("maskb", maskb_q, m[2]);
      chk("dir", dir_q, m[3]);
      chk("polar", polar_q, m[4]);
      chk("edge", edge_q, m[5]);
      chk("both", both_q, m[6]);
      chk("inen", inen_q, m[7]);
      chk("rdata", bus_rdata, m_rd);
      chk("err", {15'h0, bus_err}, {15'h0, m_err});
    end
  end

  task automatic drive(input logic w, input logic r, input logic [1:0] sz,
                       input logic [6:0] a, input logic [15:0] d,
                       input logic [15:0] pe, input logic [15:0] pv);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_size = sz; bus_addr = a; bus_wdata = d;
    pin_upd_en = pe; pin_upd_val = pv;
  endtask

  task automatic wr16(input logic [6:0] a, input logic [15:0] d);
    drive(1'b1, 1'b0, 2'b01, a, d, 16'h0, 16'h0);
  endtask

  task automatic rd16(input logic [6:0] a);
    drive(1'b0, 1'b1, 2'b01, a, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 2'b01, 7'h0, 16'h0, 16'h0, 16'h0);
  endtask

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();

    cur_req = "R2";
    wr16(7'h00, 16'h1234); wr16(7'h10, 16'h0F0F); wr16(7'h20, 16'hA5A5);
    wr16(7'h30, 16'h00FF); wr16(7'h34, 16'h3C3C); wr16(7'h38, 16'h8001);
    wr16(7'h3C, 16'h7E7E); wr16(7'h40, 16'hC003);
    wr16(7'h10, 16'hFFF0);
    idle();

    cur_req = "R6";
    for (int a = 0; a <= 64; a += 4) rd16(7'(a));
    idle();

    cur_req = "R3";
    wr16(7'h04, 16'h0230); wr16(7'h14, 16'h00FF); wr16(7'h24, 16'hF00F);
    rd16(7'h04); rd16(7'h24); idle();

    cur_req = "R4";
    wr16(7'h08, 16'h8001); wr16(7'h18, 16'h0A0A); wr16(7'h28, 16'h0660);
    rd16(7'h08); rd16(7'h18); idle();

    cur_req = "R5";
    wr16(7'h0C, 16'hFFFF); wr16(7'h1C, 16'h5555); wr16(7'h2C, 16'h0FF0);
    wr16(7'h1C, 16'h5555);
    rd16(7'h0C); rd16(7'h2C); idle();

    cur_req = "R7";
    drive(1'b1, 1'b0, 2'b00, 7'h00, 16'hDEAD, 16'h0, 16'h0);
    drive(1'b1, 1'b0, 2'b10, 7'h10, 16'hBEEF, 16'h0, 16'h0);
    drive(1'b1, 1'b0, 2'b11, 7'h30, 16'h1111, 16'h0, 16'h0);
    drive(1'b0, 1'b1, 2'b10, 7'h00, 16'h0, 16'h0, 16'h0);
    idle(); rd16(7'h00); idle();

    cur_req = "R8";
    wr16(7'h44, 16'hFFFF); wr16(7'h7C, 16'hFFFF); wr16(7'h02, 16'hFFFF);
    wr16(7'h31, 16'hFFFF); rd16(7'h48); rd16(7'h06); idle();
    rd16(7'h30); idle();

    cur_req = "R9";
    drive(1'b0, 1'b0, 2'b01, 7'h0, 16'h0, 16'h00FF, 16'hAAAA);
    drive(1'b0, 1'b0, 2'b01, 7'h0, 16'h0, 16'hF000, 16'h0000);
    drive(1'b1, 1'b0, 2'b01, 7'h10, 16'h1357, 16'h0F00, 16'h0F00);
    drive(1'b1, 1'b0, 2'b01, 7'h44, 16'hFFFF, 16'h0003, 16'h0001);
    idle(); rd16(7'h00); idle();

    cur_req = "R10";
    drive(1'b1, 1'b0, 2'b01, 7'h00, 16'h4242, 16'hFFFF, 16'h0000);
    drive(1'b1, 1'b0, 2'b01, 7'h0C, 16'h00FF, 16'hFF00, 16'hFF00);
    drive(1'b1, 1'b0, 2'b01, 7'h04, 16'h0002, 16'h000F, 16'h000F);
    drive(1'b1, 1'b0, 2'b01, 7'h08, 16'h8000, 16'h00F0, 16'h0000);
    idle(); rd16(7'h00); idle(); idle();

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle(); idle();
    rst_n = 1'b1;
    idle(); idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule